// File: doc/BRIEF.md
# Selectable-Length Pseudo-Random Bit Sequence Generator

This block is a Fibonacci linear feedback shift register that produces a maximal-length pseudo-random bit stream for exercising serial links and other data paths under test. A two-bit length select chooses one of four standard register lengths: 5, 7, 23 or 31 stages. Each length has its own feedback tap. A mode input selects plain XOR feedback or inverted (XNOR) feedback. When the enable is high, the register advances one step per clock. The serial bit and the whole state word are presented at the outputs.

Each feedback mode has one state from which the register can never leave. With XOR feedback this is all zeros of the active length. With XNOR feedback it is all ones. The block prevents entry into that state wherever it can: at reset, on a seed write and on a length change. If the register still ends up holding it, for example because the mode input flips under a running sequence, the block raises a flag and reloads a safe default on the next enabled step. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `prbs_gen`

## Requirements
- R1: On the first clock after reset is released, the state becomes the default seed for the current mode. For XOR mode (mode_xnor=0) this is all ones across the active stages. For XNOR mode (mode_xnor=1) it is all zeros. Stages above the active length always read 0 on state_out, and lockup stays low throughout reset.
- R2: len_sel encodes the length and tap as follows: 0 gives 5 stages with tap 3, 1 gives 7 stages with tap 6, 2 gives 23 stages with tap 18, and 3 gives 31 stages with tap 28. The polynomials are x^W + x^T + 1.
- R3: On an enabled step, the state shifts one place toward the MSB. Bit 0 receives state[W-1] XOR state[T-1] in XOR mode, or the inverse of that value in XNOR mode.
- R4: With 5 stages and XOR feedback, the sequence visits 31 distinct nonzero states and then repeats.
- R5: With 5 stages and XNOR feedback, the sequence includes the all-zeros state, never visits the all-ones state, and repeats after 31 steps.
- R6: bit_out equals state_out[W-1], the top stage of the active length.
- R7: Over the 5-stage XOR sequence, the longest run of ones on bit_out is 5 and the longest run of zeros is 4.
- R8: While en, seed_load and a length change are all absent, the state holds.
- R9: seed_load writes seed_val, masked to the active stages, whether or not en is high. If the masked value equals the forbidden state for the current mode, the default seed is written in its place.
- R10: lockup is high whenever the active stages hold the forbidden state for the current mode. The next enabled clock then loads the default seed instead of stepping.
- R11: If len_sel differs from the length in use, the next clock loads the default seed for the new length, whether or not en is high. This load takes priority over seed_load and over stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Step enable |
| len_sel | input | 2 | Register length select |
| mode_xnor | input | 1 | 0: XOR feedback, 1: XNOR feedback |
| seed_load | input | 1 | Write seed_val into the register |
| seed_val | input | MAX_W | Seed value |
| bit_out | output | 1 | Serial output bit (top active stage) |
| state_out | output | MAX_W | Register state, inactive stages zero |
| lockup | output | 1 | Register holds the forbidden state for the mode |

## Verification
The hardest situation to reach is a register that actually holds its forbidden state, because reset, seed writes and length changes all steer around it. The bench gets there by resetting in XOR mode, which gives all ones, and then raising mode_xnor with en low. The unchanged all-ones state becomes forbidden under the new mode. The bench then checks the flag in that cycle and the default reload on the next enabled clock. Every other mode and length is compared step by step against a model built from the tap table.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [1:0] {
    LEN_5  = 2'd0,
    LEN_7  = 2'd1,
    LEN_23 = 2'd2,
    LEN_31 = 2'd3
  } prbs_len_e;

  function automatic int stage_count(prbs_len_e len);
    case (len)
      LEN_5:   return 5;
      LEN_7:   return 7;
      LEN_23:  return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int tap_stage(prbs_len_e len);
    case (len)
      LEN_5:   return 3;
      LEN_7:   return 6;
      LEN_23:  return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/prbs_len_decode.sv
module prbs_len_decode
  import prbs_pkg::*;
#(
  parameter int MAX_W = 31,
  localparam int IDX_W = $clog2(MAX_W)
) (
  input  prbs_len_e          len,
  output logic [MAX_W-1:0]   mask,
  output logic [IDX_W-1:0]   msb_idx,
  output logic [IDX_W-1:0]   tap_idx
);
  int nstages;

  assign nstages = stage_count(len);
  assign msb_idx = IDX_W'(nstages - 1);
  assign tap_idx = IDX_W'(tap_stage(len) - 1);

  for (genvar i = 0; i < MAX_W; i++) begin : g_mask
    assign mask[i] = (i < nstages);
  end
endmodule

// File: rtl/prbs_feedback.sv
module prbs_feedback #(
  parameter int MAX_W = 31,
  localparam int IDX_W = $clog2(MAX_W)
) (
  input  logic [MAX_W-1:0] state,
  input  logic [MAX_W-1:0] mask,
  input  logic [IDX_W-1:0] msb_idx,
  input  logic [IDX_W-1:0] tap_idx,
  input  logic             invert,
  output logic [MAX_W-1:0] shifted
);
  logic fb;

  assign fb      = state[msb_idx] ^ state[tap_idx] ^ invert;
  assign shifted = {state[MAX_W-2:0], fb} & mask;
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int MAX_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       len_sel,
  input  logic             mode_xnor,
  input  logic             seed_load,
  input  logic [MAX_W-1:0] seed_val,
  output logic             bit_out,
  output logic [MAX_W-1:0] state_out,
  output logic             lockup
);
  localparam int IDX_W = $clog2(MAX_W);

  logic             rst_n_s;
  prbs_len_e        len_q;
  logic             pend_q;
  logic [MAX_W-1:0] state_q, state_d;

  logic [MAX_W-1:0] mask_act, mask_new;
  logic [IDX_W-1:0] msb_act, tap_act, msb_new, tap_new;
  logic [MAX_W-1:0] shifted, lock_pat, dflt_act, dflt_new, ld_val;
  logic             len_chg, is_lock;

  prbs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  prbs_len_decode #(.MAX_W(MAX_W)) u_dec_act (
    .len(len_q), .mask(mask_act), .msb_idx(msb_act), .tap_idx(tap_act));

  prbs_len_decode #(.MAX_W(MAX_W)) u_dec_new (
    .len(prbs_len_e'(len_sel)), .mask(mask_new), .msb_idx(msb_new), .tap_idx(tap_new));

  prbs_feedback #(.MAX_W(MAX_W)) u_fb (
    .state(state_q), .mask(mask_act), .msb_idx(msb_act), .tap_idx(tap_act),
    .invert(mode_xnor), .shifted(shifted));

  assign lock_pat = mode_xnor ? mask_act : '0;
  assign dflt_act = mode_xnor ? '0 : mask_act;
  assign dflt_new = mode_xnor ? '0 : mask_new;
  assign ld_val   = seed_val & mask_act;
  assign len_chg  = (len_sel != len_q);
  assign is_lock  = !pend_q && (state_q == lock_pat);

  // next state: pending reload / length change > seed write > enabled step
  always_comb begin
    state_d = state_q;
    if (pend_q || len_chg) begin
      state_d = dflt_new;
    end else if (seed_load) begin
      state_d = (ld_val == lock_pat) ? dflt_act : ld_val;
    end else if (en) begin
      state_d = is_lock ? dflt_act : shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= '0;
      len_q   <= LEN_5;
      pend_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      len_q   <= prbs_len_e'(len_sel);
      pend_q  <= 1'b0;
    end
  end

  assign state_out = state_q;
  assign bit_out   = state_q[msb_act];
  assign lockup    = is_lock;
endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk #(
  parameter int MAX_W = 31
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             en,
  input logic [1:0]       len_sel,
  input logic             mode_xnor,
  input logic             seed_load,
  input logic [MAX_W-1:0] state_out,
  input logic             lockup,
  input logic [1:0]       len_q,
  input logic             pend_q,
  input logic [MAX_W-1:0] mask_act,
  input logic [MAX_W-1:0] mask_new
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((state_out & ~mask_act) == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!en && !seed_load && !pend_q && (len_sel == len_q)) |=> $stable(state_out));

  assert_load_safe_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (seed_load && !pend_q && (len_sel == len_q)) |=>
      ((mode_xnor != $past(mode_xnor)) || !lockup));

  assert_lock_exit_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lockup && en && !seed_load && !pend_q && (len_sel == len_q)) |=>
      (state_out == ($past(mode_xnor) ? '0 : $past(mask_act))));

  assert_len_reload_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!pend_q && (len_sel != len_q)) |=>
      (state_out == ($past(mode_xnor) ? '0 : $past(mask_new))));
endmodule

bind prbs_gen prbs_gen_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .en(en), .len_sel(len_sel), .mode_xnor(mode_xnor),
  .seed_load(seed_load), .state_out(state_out), .lockup(lockup), .len_q(len_q),
  .pend_q(pend_q), .mask_act(mask_act), .mask_new(mask_new));

// File: tb/prbs_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_gen_tb_top;
  localparam int W = 31;

  logic         clk = 1'b0;
  logic         rst_n, en, mode_xnor, seed_load;
  logic [1:0]   len_sel;
  logic [W-1:0] seed_val;
  logic         bit_out, lockup;
  logic [W-1:0] state_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  prbs_gen #(.MAX_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .len_sel(len_sel), .mode_xnor(mode_xnor),
    .seed_load(seed_load), .seed_val(seed_val), .bit_out(bit_out),
    .state_out(state_out), .lockup(lockup));

  // {len_sel, mode, seed, steps}
  localparam logic [49:0] VEC [8] = '{
    {2'd0, 1'b0, 31'h00000003, 16'd40},
    {2'd1, 1'b0, 31'h00000001, 16'd140},
    {2'd1, 1'b1, 31'h00000055, 16'd60},
    {2'd2, 1'b0, 31'h00400001, 16'd100},
    {2'd2, 1'b1, 31'h00000000, 16'd100},
    {2'd3, 1'b0, 31'h7FFFFFFF, 16'd100},
    {2'd3, 1'b1, 31'h12345678, 16'd100},
    {2'd0, 1'b1, 31'h0000000A, 16'd35}
  };

  function automatic int len_w(logic [1:0] l);
    case (l) 2'd0: return 5; 2'd1: return 7; 2'd2: return 23; default: return 31; endcase
  endfunction
  function automatic int len_t(logic [1:0] l);
    case (l) 2'd0: return 3; 2'd1: return 6; 2'd2: return 18; default: return 28; endcase
  endfunction
  function automatic logic [W-1:0] msk(logic [1:0] l);
    return (W'(1) << len_w(l)) - W'(1);
  endfunction
  function automatic logic [W-1:0] dflt(logic [1:0] l, logic m);
    return m ? '0 : msk(l);
  endfunction
  function automatic logic [W-1:0] ref_step(logic [1:0] l, logic m, logic [W-1:0] s);
    logic fbit;
    if (s == (m ? msk(l) : '0)) return dflt(l, m);
    fbit = s[len_w(l)-1] ^ s[len_t(l)-1] ^ m;
    return {s[W-2:0], fbit} & msk(l);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_s, first;
    int ones_run, zeros_run, max1, max0;
    bit seen_zero, seen_ones, early;

    rst_n = 1'b0; en = 1'b0; mode_xnor = 1'b0; seed_load = 1'b0;
    len_sel = 2'd0; seed_val = '0;
    repeat (3) @(negedge clk);
    check("R1 lockup in reset", 64'(lockup), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset seed xor", 64'(state_out), 64'h1F);
    check("R6 bit_out top stage", 64'(bit_out), 64'd1);

    // R4 / R7: 5-stage XOR period and runs
    first = state_out; early = 1'b0; seen_zero = 1'b0;
    ones_run = 0; zeros_run = 0; max1 = 0; max0 = 0;
    en = 1'b1;
    for (int i = 1; i <= 62; i++) begin
      if (bit_out) begin ones_run++; zeros_run = 0; end
      else begin zeros_run++; ones_run = 0; end
      if (ones_run > max1) max1 = ones_run;
      if (zeros_run > max0) max0 = zeros_run;
      @(negedge clk);
      if (state_out == '0) seen_zero = 1'b1;
      if (i < 31 && state_out == first) early = 1'b1;
      if (i == 31) check("R4 period 31 xor", 64'(state_out), 64'(first));
    end
    check("R4 no zero state, no early repeat", 64'({seen_zero, early}), 64'd0);
    check("R7 longest ones run", 64'(max1), 64'd5);
    check("R7 longest zeros run", 64'(max0), 64'd4);

    // R8 hold with en low
    en = 1'b0;
    exp_s = state_out;
    repeat (5) @(negedge clk);
    check("R8 hold", 64'(state_out), 64'(exp_s));

    // R10: force lockup by mode flip on all-ones state
    seed_val = 31'h1F; seed_load = 1'b1;   // all ones is legal in XOR mode
    @(negedge clk);
    seed_load = 1'b0;
    check("R9 load legal", 64'(state_out), 64'h1F);
    mode_xnor = 1'b1;
    #1;
    check("R10 lockup flag raised", 64'(lockup), 64'd1);
    @(negedge clk);
    check("R10 no reload while en low", 64'(state_out), 64'h1F);
    en = 1'b1;
    @(negedge clk);
    check("R10 reload default xnor", 64'(state_out), 64'h00);
    check("R10 flag cleared", 64'(lockup), 64'd0);

    // R5: 5-stage XNOR period from zero
    seen_ones = 1'b0; early = 1'b0;
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk);
      if (state_out == 31'h1F) seen_ones = 1'b1;
      if (i < 31 && state_out == '0) early = 1'b1;
    end
    check("R5 xnor period 31", 64'(state_out), 64'h00);
    check("R5 no all-ones, no early repeat", 64'({seen_ones, early}), 64'd0);

    // R9 seed write with forbidden masked value, en low
    en = 1'b0; mode_xnor = 1'b0;
    seed_val = 31'h7FFFFFE0; seed_load = 1'b1;
    @(negedge clk);
    check("R9 forbidden seed replaced", 64'(state_out), 64'h1F);
    seed_val = 31'h7FFFFF92;
    @(negedge clk);
    seed_load = 1'b0;
    check("R9 seed masked", 64'(state_out), 64'h12);

    // R11 length change beats seed_load
    len_sel = 2'd1; seed_load = 1'b1; seed_val = 31'h5;
    @(negedge clk);
    seed_load = 1'b0;
    check("R11 length change reload", 64'(state_out), 64'h7F);
    check("R6 bit_out 7-stage", 64'(bit_out), 64'd1);

    // R2/R3: vector table against the tap model
    for (int v = 0; v < 8; v++) begin
      logic [1:0] l; logic m; logic [W-1:0] sd; int n;
      {l, m, sd, n} = {VEC[v][49:48], VEC[v][47], VEC[v][46:16], 32'(VEC[v][15:0])};
      en = 1'b0; len_sel = l; mode_xnor = m;
      @(negedge clk);
      seed_val = sd; seed_load = 1'b1;
      @(negedge clk);
      seed_load = 1'b0;
      exp_s = sd & msk(l);
      if (exp_s == (m ? msk(l) : '0)) exp_s = dflt(l, m);
      check("R9 table seed", 64'(state_out), 64'(exp_s));
      en = 1'b1;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        exp_s = ref_step(l, m, exp_s);
        check("R3 step", 64'(state_out), 64'(exp_s));
        check("R6 serial bit", 64'(bit_out), 64'(exp_s[len_w(l)-1]));
      end
      check("R2 inactive stages zero", 64'(state_out & ~msk(l)), 64'd0);
    end

    // R1 reset in XNOR mode
    en = 1'b0; mode_xnor = 1'b1; len_sel = 2'd2;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset seed xnor", 64'(state_out), 64'd0);
    check("R1 no lockup after reset", 64'(lockup), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule